// File: doc/BRIEF.md
# Break Return Address Selector

This block watches an in-order instruction stream, one slot per accepted transfer, and turns a breakpoint hit into a precisely placed break. For each hit it decides two things. The first is whether the break suppresses the hit instruction or waits for it, and possibly for a few more, to complete. The second is which return address is written to the saved-PC register before exception entry. The choice depends on the 2-bit kind of match and on whether a delayed branch or its delay slot is involved. A break must never fall between a delayed branch and its slot.

Slots arrive on a valid/ready handshake. A slot is consumed in any cycle where `in_valid` and `in_ready` are both high, and only consumed slots count or decide anything. The block applies back-pressure only around a break. `in_ready` drops in the cycle the saved-PC strobe is raised and in the cycle after it, and it rises again in the third cycle after the deciding slot. While `in_ready` is low, the upstream stage holds its slot. A data-qualified hit breaks after a lag of 1 to 6 consumed slots. The lag is taken from an input when the hit is consumed.

Top module: `brk_ret_sel`

## Requirements
- R1: A consumed hit with kind 00 (fetch, break before) on a slot not flagged as a delay slot raises `brk_kill` in that cycle. In the next cycle `spc_we` is high and `spc_value` equals that slot's address.
- R2: A kind-00 hit on a slot flagged as a delay slot is also killed. The saved value is the address of the most recently consumed delayed branch.
- R3: A kind-01 hit (fetch, break after) on a plain slot raises `brk_post` and saves that slot's sequential next address.
- R4: A kind-01 hit on a delayed branch produces no break in that cycle. The next consumed slot (its delay slot) raises `brk_post`, and the branch's target is saved. A kind-01 hit on a delay slot raises `brk_post` and saves the target of the last consumed delayed branch.
- R5: A kind-10 hit (operand, address only) saves the next address on a plain slot and the last branch target on a delay slot. On a delayed branch it waits for the slot, as in R4.
- R6: A kind-11 hit (operand, address plus data) lets the hit slot complete and samples `data_lag`, clamped so that 0 becomes 1 and 7 becomes 6. The following L-1 consumed slots run without a break. The L-th one is killed and its own address is saved.
- R7: If the L-th slot after a kind-11 hit is a delayed branch, it completes, its delay slot raises `brk_post`, and the branch target is saved. If the L-th slot is a delay slot, it raises `brk_post` and the last branch target is saved.
- R8: Only one break is pending at a time. Hits consumed while a lag is counting or while a delay slot is awaited are ignored. `spc_we` lasts one cycle, and `in_ready` is low in that cycle and the next, then high again.
- R9: A synchronous active-high `rst` returns `in_ready` high and `spc_we` low and discards any counting lag. No break follows a hit consumed before reset.
- R10: Cycles with `in_valid` low do not advance the lag count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Slot fields are valid |
| in_ready | output | 1 | Block accepts a slot this cycle |
| slot_addr | input | AW | Address of the slot's instruction |
| slot_next | input | AW | Sequential next address |
| slot_target | input | AW | Branch destination (meaningful on delayed branches) |
| slot_is_branch | input | 1 | Slot is a delayed branch |
| slot_is_dslot | input | 1 | Slot is a delay slot |
| slot_match | input | 1 | Breakpoint hit on this slot |
| slot_kind | input | 2 | Hit kind: 00 fetch-before, 01 fetch-after, 10 operand address, 11 operand address+data |
| data_lag | input | 3 | Lag for kind 11, clamped to 1..6 |
| brk_kill | output | 1 | Consumed slot must not execute; break taken before it |
| brk_post | output | 1 | Consumed slot completes; break taken after it |
| spc_value | output | AW | Return address for the saved-PC register |
| spc_we | output | 1 | Saved-PC write strobe |

## Verification
A wrong internal state is mostly visible as a break on the wrong slot. If the lag counter is off by one, the kill lands one consumed slot early or late, so it appears within at most seven slots of a data hit. If the branch tracker is stale, a hit inside a delay slot saves the wrong address, and this shows on `spc_value` in the cycle after that slot. If the control sequencer is stuck, `in_ready` stays low or a second strobe appears, and either is visible no later than the third cycle after the deciding slot.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH_PRE  = 2'b00,
    KIND_FETCH_POST = 2'b01,
    KIND_OPND_ADDR  = 2'b10,
    KIND_OPND_DATA  = 2'b11
  } hit_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_KILL,
    ACT_POST,
    ACT_AWAIT,
    ACT_COUNT
  } brk_act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_AWAIT,
    ST_FIRE,
    ST_CLEAR
  } brk_state_e;

endpackage

// File: rtl/brs_branch_track.sv
module brs_branch_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          is_branch,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] last_addr,
  output logic [AW-1:0] last_target
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr   <= '0;
      last_target <= '0;
    end else if (take && is_branch) begin
      last_addr   <= br_addr;
      last_target <= br_target;
    end
  end

endmodule

// File: rtl/brs_lag_ctr.sv
module brs_lag_ctr #(
  parameter int LW      = 3,
  parameter int LAG_MIN = 1,
  parameter int LAG_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] lag_in,
  input  logic          step,
  output logic          at_end
);

  localparam logic [LW-1:0] LO = LW'(LAG_MIN);
  localparam logic [LW-1:0] HI = LW'(LAG_MAX);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] lag_clamped;

  always_comb begin
    if (lag_in < LO)      lag_clamped = LO;
    else if (lag_in > HI) lag_clamped = HI;
    else                  lag_clamped = lag_in;
  end

  always_ff @(posedge clk) begin
    if (rst)                            cnt_q <= '0;
    else if (load)                      cnt_q <= lag_clamped;
    else if (step && cnt_q > LW'(1))    cnt_q <= cnt_q - LW'(1);
  end

  assign at_end = (cnt_q == LW'(1));

  p_lag_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= HI);

  p_lag_load_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q >= LO && cnt_q <= HI));

  p_lag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/brs_decide.sv
module brs_decide
  import brs_pkg::*;
#(
  parameter int AW = 32
) (
  input  brk_state_e    state,
  input  logic [AW-1:0] slot_addr,
  input  logic [AW-1:0] slot_next,
  input  logic [AW-1:0] slot_target,
  input  logic          slot_is_branch,
  input  logic          slot_is_dslot,
  input  logic          slot_match,
  input  logic [1:0]    slot_kind,
  input  logic [AW-1:0] last_addr,
  input  logic [AW-1:0] last_target,
  input  logic [AW-1:0] await_target,
  input  logic          lag_end,
  output brk_act_e      act,
  output logic [AW-1:0] act_addr
);

  hit_kind_e kind;
  assign kind = hit_kind_e'(slot_kind);

  always_comb begin
    act      = ACT_NONE;
    act_addr = slot_addr;
    unique case (state)
      ST_IDLE: begin
        if (slot_match) begin
          unique case (kind)
            KIND_FETCH_PRE: begin
              act      = ACT_KILL;
              act_addr = slot_is_dslot ? last_addr : slot_addr;
            end
            KIND_FETCH_POST, KIND_OPND_ADDR: begin
              if (slot_is_branch) begin
                act      = ACT_AWAIT;
                act_addr = slot_target;
              end else if (slot_is_dslot) begin
                act      = ACT_POST;
                act_addr = last_target;
              end else begin
                act      = ACT_POST;
                act_addr = slot_next;
              end
            end
            KIND_OPND_DATA: begin
              act      = ACT_COUNT;
              act_addr = slot_addr;
            end
            default: act = ACT_NONE;
          endcase
        end
      end
      ST_COUNT: begin
        if (lag_end) begin
          if (slot_is_branch) begin
            act      = ACT_AWAIT;
            act_addr = slot_target;
          end else if (slot_is_dslot) begin
            act      = ACT_POST;
            act_addr = last_target;
          end else begin
            act      = ACT_KILL;
            act_addr = slot_addr;
          end
        end
      end
      ST_AWAIT: begin
        act      = ACT_POST;
        act_addr = await_target;
      end
      default: begin
        act      = ACT_NONE;
        act_addr = slot_addr;
      end
    endcase
  end

endmodule

// File: rtl/brk_ret_sel.sv
module brk_ret_sel
  import brs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 3,
  parameter int LAG_MIN = 1,
  parameter int LAG_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] slot_addr,
  input  logic [AW-1:0] slot_next,
  input  logic [AW-1:0] slot_target,
  input  logic          slot_is_branch,
  input  logic          slot_is_dslot,
  input  logic          slot_match,
  input  logic [1:0]    slot_kind,
  input  logic [LW-1:0] data_lag,
  output logic          brk_kill,
  output logic          brk_post,
  output logic [AW-1:0] spc_value,
  output logic          spc_we
);

  brk_state_e    state_q, state_d;
  brk_act_e      act;
  logic [AW-1:0] act_addr;
  logic [AW-1:0] tgt_q;
  logic [AW-1:0] last_addr, last_target;
  logic          take;
  logic          lag_end;
  logic          lag_load, lag_step;

  assign in_ready = (state_q == ST_IDLE) || (state_q == ST_COUNT) ||
                    (state_q == ST_AWAIT);
  assign take     = in_valid && in_ready;

  brs_branch_track #(.AW(AW)) u_track (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .is_branch   (slot_is_branch),
    .br_addr     (slot_addr),
    .br_target   (slot_target),
    .last_addr   (last_addr),
    .last_target (last_target)
  );

  brs_decide #(.AW(AW)) u_decide (
    .state          (state_q),
    .slot_addr      (slot_addr),
    .slot_next      (slot_next),
    .slot_target    (slot_target),
    .slot_is_branch (slot_is_branch),
    .slot_is_dslot  (slot_is_dslot),
    .slot_match     (slot_match),
    .slot_kind      (slot_kind),
    .last_addr      (last_addr),
    .last_target    (last_target),
    .await_target   (tgt_q),
    .lag_end        (lag_end),
    .act            (act),
    .act_addr       (act_addr)
  );

  assign lag_load = take && (state_q == ST_IDLE) && (act == ACT_COUNT);
  assign lag_step = take && (state_q == ST_COUNT) && (act == ACT_NONE);

  brs_lag_ctr #(.LW(LW), .LAG_MIN(LAG_MIN), .LAG_MAX(LAG_MAX)) u_lag (
    .clk    (clk),
    .rst    (rst),
    .load   (lag_load),
    .lag_in (data_lag),
    .step   (lag_step),
    .at_end (lag_end)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_COUNT, ST_AWAIT: begin
        if (take) begin
          unique case (act)
            ACT_KILL, ACT_POST: state_d = ST_FIRE;
            ACT_AWAIT:          state_d = ST_AWAIT;
            ACT_COUNT:          state_d = ST_COUNT;
            default:            state_d = state_q;
          endcase
        end
      end
      ST_FIRE:  state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take && (act == ACT_KILL || act == ACT_POST || act == ACT_AWAIT))
        tgt_q <= act_addr;
    end
  end

  assign brk_kill  = take && (act == ACT_KILL);
  assign brk_post  = take && (act == ACT_POST);
  assign spc_we    = (state_q == ST_FIRE);
  assign spc_value = tgt_q;

  p_kill_post_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(brk_kill && brk_post));

  p_decide_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    (brk_kill || brk_post) |=> spc_we);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    spc_we |=> (!spc_we && !in_ready));

  p_ready_back_r8: assert property (@(posedge clk) disable iff (rst)
    spc_we |=> ##1 in_ready);

  p_spc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    spc_we |=> $stable(spc_value));

  p_no_decide_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !(brk_kill || brk_post));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!spc_we && in_ready));

endmodule

// File: tb/sim_brk_ret_sel.sv
`timescale 1ns/1ps
module sim_brk_ret_sel;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] slot_addr, slot_next, slot_target;
  logic        slot_is_branch, slot_is_dslot, slot_match;
  logic [1:0]  slot_kind;
  logic [2:0]  data_lag;
  logic        brk_kill, brk_post;
  logic [31:0] spc_value;
  logic        spc_we;

  int checks = 0;
  int errors = 0;
  logic k_s, p_s, r_s;

  always #2 clk = ~clk;

  brk_ret_sel u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .slot_addr(slot_addr), .slot_next(slot_next), .slot_target(slot_target),
    .slot_is_branch(slot_is_branch), .slot_is_dslot(slot_is_dslot),
    .slot_match(slot_match), .slot_kind(slot_kind), .data_lag(data_lag),
    .brk_kill(brk_kill), .brk_post(brk_post), .spc_value(spc_value),
    .spc_we(spc_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one slot at a negedge, sample decision outputs, let it be consumed,
  // and return at the following negedge.
  task automatic step(input logic [31:0] a, input logic [31:0] tg,
                      input logic db, input logic ds, input logic m,
                      input logic [1:0] kd, input logic [2:0] lg);
    in_valid = 1'b1; slot_addr = a; slot_next = a + 32'd2; slot_target = tg;
    slot_is_branch = db; slot_is_dslot = ds; slot_match = m;
    slot_kind = kd; data_lag = lg;
    #1;
    k_s = brk_kill; p_s = brk_post; r_s = in_ready;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; slot_match = 1'b0;
  endtask

  task automatic bubble();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_break(input string req);
    @(negedge clk);
    chk({req, " strobe drops"}, spc_we, 0);
    chk({req, " ready low after strobe"}, in_ready, 0);
    @(negedge clk);
    chk({req, " ready back"}, in_ready, 1);
  endtask

  task automatic t_reset();
    chk("R9 reset ready", in_ready, 1);
    chk("R9 reset strobe", spc_we, 0);
  endtask

  task automatic t_fetch_pre();
    step(32'h100, 0, 0, 0, 1, 2'b00, 0);
    chk("R1 kill", k_s, 1);
    chk("R1 no post", p_s, 0);
    chk("R1 strobe", spc_we, 1);
    chk("R1 addr", spc_value, 32'h100);
    chk("R8 ready low in strobe cycle", in_ready, 0);
    finish_break("R8");
    step(32'h200, 32'h300, 1, 0, 0, 2'b00, 0);
    step(32'h202, 0, 0, 1, 1, 2'b00, 0);
    chk("R2 kill", k_s, 1);
    chk("R2 branch addr", spc_value, 32'h200);
    chk("R2 strobe", spc_we, 1);
    finish_break("R2");
  endtask

  task automatic t_fetch_post();
    step(32'h400, 0, 0, 0, 1, 2'b01, 0);
    chk("R3 post", p_s, 1);
    chk("R3 next addr", spc_value, 32'h402);
    finish_break("R3");
    step(32'h500, 32'h600, 1, 0, 1, 2'b01, 0);
    chk("R4 branch no break", k_s | p_s, 0);
    chk("R4 no strobe yet", spc_we, 0);
    step(32'h502, 0, 0, 1, 0, 2'b00, 0);
    chk("R4 slot post", p_s, 1);
    chk("R4 target", spc_value, 32'h600);
    finish_break("R4");
    step(32'h520, 32'h640, 1, 0, 0, 2'b00, 0);
    step(32'h522, 0, 0, 1, 1, 2'b01, 0);
    chk("R4 dslot post", p_s, 1);
    chk("R4 dslot target", spc_value, 32'h640);
    finish_break("R4");
  endtask

  task automatic t_opnd_addr();
    step(32'h700, 0, 0, 0, 1, 2'b10, 0);
    chk("R5 post", p_s, 1);
    chk("R5 next addr", spc_value, 32'h702);
    finish_break("R5");
    step(32'h740, 32'h780, 1, 0, 0, 2'b00, 0);
    step(32'h742, 0, 0, 1, 1, 2'b10, 0);
    chk("R5 dslot target", spc_value, 32'h780);
    finish_break("R5");
    step(32'h750, 32'h790, 1, 0, 1, 2'b10, 0);
    chk("R5 branch waits", spc_we, 0);
    step(32'h752, 0, 0, 1, 0, 2'b00, 0);
    chk("R5 branch target", spc_value, 32'h790);
    finish_break("R5");
  endtask

  task automatic t_data_lag();
    for (int lg = 0; lg < 8; lg++) begin
      int stop;
      logic [31:0] base;
      stop = (lg < 1) ? 1 : (lg > 6) ? 6 : lg;
      base = 32'h1000 + 32'(lg) * 32'h100;
      step(base, 0, 0, 0, 1, 2'b11, 3'(lg));
      chk("R6 hit runs", k_s | p_s, 0);
      chk("R6 no strobe on hit", spc_we, 0);
      for (int j = 1; j <= stop; j++) begin
        if (j == 2) bubble();  // R10: idle cycle must not count
        if (j < stop) begin
          step(base + 32'(2*j), 0, 0, 0, 1, 2'b00, 0);
          chk("R8 hit ignored while counting", k_s | p_s, 0);
          chk("R6 no early strobe", spc_we, 0);
        end else begin
          step(base + 32'(2*j), 0, 0, 0, 0, 2'b00, 0);
          chk("R6 kill at lag end", k_s, 1);
          chk("R6 strobe", spc_we, 1);
          chk("R6 addr of lag slot", spc_value, base + 32'(2*j));
        end
      end
      finish_break("R6");
    end
  endtask

  task automatic t_data_branch();
    step(32'h2000, 0, 0, 0, 1, 2'b11, 3'd2);
    step(32'h2002, 0, 0, 0, 0, 2'b00, 0);
    step(32'h2004, 32'h3000, 1, 0, 0, 2'b00, 0);
    chk("R7 branch completes", k_s | p_s, 0);
    chk("R7 no strobe at branch", spc_we, 0);
    step(32'h2006, 0, 0, 1, 0, 2'b00, 0);
    chk("R7 slot post", p_s, 1);
    chk("R7 target", spc_value, 32'h3000);
    finish_break("R7");
    step(32'h2100, 32'h3100, 1, 0, 1, 2'b11, 3'd1);
    step(32'h2102, 0, 0, 1, 0, 2'b00, 0);
    chk("R7 lag ends in dslot post", p_s, 1);
    chk("R7 dslot target", spc_value, 32'h3100);
    finish_break("R7");
  endtask

  task automatic t_reset_mid();
    step(32'h4000, 0, 0, 0, 1, 2'b11, 3'd6);
    step(32'h4002, 0, 0, 0, 0, 2'b00, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 ready after reset", in_ready, 1);
    for (int j = 0; j < 7; j++) begin
      step(32'h4100 + 32'(2*j), 0, 0, 0, 0, 2'b00, 0);
      chk("R9 no break after reset", k_s | p_s | spc_we, 0);
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; slot_addr = '0; slot_next = '0;
    slot_target = '0; slot_is_branch = 1'b0; slot_is_dslot = 1'b0;
    slot_match = 1'b0; slot_kind = 2'b00; data_lag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fetch_pre();
    t_fetch_post();
    t_opnd_addr();
    t_data_lag();
    t_data_branch();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule